// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory whose reads and writes share one pipeline of fixed depth. Every command (address, direction, byte enables, chip selects) is captured on a rising clock edge. A read returns its word two enabled edges later from a registered output. A write takes its data two enabled edges after its address, which is the same slot a read would use to return data. Because of this, a read may follow a write, or a write may follow a read, on the very next cycle, and the shared data path never needs an idle slot.

The array is read at the middle stage of the pipeline. A write that is committing on that same edge would be missed by the array read, so its enabled bytes are forwarded into the read result. A read therefore always sees every write issued before it. A load/advance control starts a four-word burst. Advance cycles repeat the last loaded direction on the next address of the burst, in either linear or interleaved order. A clock enable freezes the whole block. Three chip selects must all be high for a load to take effect.

The default depth is kept small for elaboration. Setting `ADDR_W` to 17 gives the full 131072 x 36 organisation.

Top module: `zbt_sram`

## Requirements
- R1: While `rst` is high at a clock edge, `rvalid` is cleared and `rdata` becomes zero, and no command is left in flight.
- R2: A read loaded at enabled edge k puts the stored word on `rdata` with `rvalid` high right after enabled edge k+2. If the next command is not a read, `rvalid` is high for exactly that one slot.
- R3: A write loaded at enabled edge k stores the `wdata` value that is present at enabled edge k+2.
- R4: Any mix of reads and writes can be issued on consecutive enabled cycles, one command per cycle. Every command completes in order, with no idle cycle at a direction change.
- R5: For a write, `byte_en[i]` set to 1 writes bits [9i+8:9i]. Lanes whose enable is 0 keep their stored value, so `byte_en` = 0000 changes nothing.
- R6: A load (`adv_ld`=0) takes effect only when all three bits of `chip_sel` are 1. Otherwise the slot is a deselect: nothing is written, `rvalid` is 0 in its output slot, and any advance cycles that follow remain deselects.
- R7: When `clk_en` is 0 at an edge, no state changes: `rdata` and `rvalid` hold, and all other inputs (including `wdata`) are ignored.
- R8: A read returns the word as left by all earlier-issued writes. This includes a write issued on the immediately preceding cycle to the same address, whose enabled bytes are merged over the stored word.
- R9: With `adv_ld`=1 the block repeats the direction of the last load. Address bits [ADDR_W-1:2] stay at the loaded value. The nth advance (n=1,2,3,4,...) sets bits [1:0] to (base+n) mod 4 when `burst_lin`=1, and to base XOR (n mod 4) when `burst_lin`=0.
- R10: `rvalid` is 0 in every output slot that belongs to a write, a deselect or an idle pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = pipeline advances this edge, 0 = freeze |
| chip_sel | input | 3 | Chip selects, all must be 1 on a load |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rd_wr | input | 1 | On a load: 1 = read, 0 = write |
| burst_lin | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| addr | input | ADDR_W | Word address on a load |
| byte_en | input | 4 | Per-lane write enables, lane i = bits [9i+8:9i] |
| wdata | input | 36 | Write data, taken two enabled edges after its address |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | 1 when `rdata` carries a read result for this slot |

## Verification
The first directed pattern writes an address and reads it back on the next cycle. This is the only case that needs forwarding, so it separates a correct merge from one that returns stale array data. A strict read/write alternation on one address, and runs of writes with partial lane masks, show that turnarounds lose no slot and that masked lanes survive. Deselects with each single select low, and stalls placed inside a write's data window, show that rejected and frozen cycles leave both memory and outputs unchanged. Linear and interleaved bursts from an unaligned base tell the two address orders apart. A long random mix of loads, advances, deselects and stalls over a small address range is then checked against an independent reference model.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Burst length of four words is fixed behaviour: two low address bits
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zbt_op_e;

    // Low address bits of a burst word for a given step from the base
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] step,
        input logic               linear
    );
        logic [BURST_W-1:0] res;
        if (linear) res = base + step;
        else        res = base ^ step;
        return res;
    endfunction

endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CS_W   = 3,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [CS_W-1:0]   chip_sel,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_en,
    output zbt_op_e           cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_be
);

    zbt_op_e             burst_op_q;
    logic [ADDR_W-1:0]   base_q;
    logic [BURST_W-1:0]  step_q;
    logic [BURST_W-1:0]  step_nx;
    logic                all_sel;

    assign all_sel = &chip_sel;
    assign step_nx = step_q + 1'b1;
    assign cmd_be  = byte_en;

    always_comb begin
        if (!adv_ld) begin
            cmd_addr = addr;
            if (all_sel) cmd_op = rd_wr ? OP_READ : OP_WRITE;
            else         cmd_op = OP_IDLE;
        end else begin
            cmd_op   = burst_op_q;
            cmd_addr = {base_q[ADDR_W-1:BURST_W],
                        burst_offset(base_q[BURST_W-1:0], step_nx, burst_lin)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_op_q <= OP_IDLE;
            base_q     <= '0;
            step_q     <= '0;
        end else if (clk_en) begin
            if (!adv_ld) begin
                burst_op_q <= cmd_op;
                base_q     <= addr;
                step_q     <= '0;
            end else begin
                step_q     <= step_nx;
            end
        end
    end

    // A rejected load leaves the burst engine idle for following advances
    assert_deselect_idles_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv_ld && !(&chip_sel)) |=> (burst_op_q == OP_IDLE));

    assert_freeze_burst_R7: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(step_q) && $stable(base_q) && $stable(burst_op_q)));

    assert_adv_keeps_base_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv_ld) |=> ($stable(base_q) && $stable(burst_op_q)));

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[l]) store[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/zbt_data_pipe.sv
module zbt_data_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  zbt_op_e           cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LANES-1:0]  cmd_be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [LANES-1:0]  mem_wbe,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        zbt_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    be;
    } slot_t;

    slot_t               s1_q, s2_q;
    logic [DATA_W-1:0]   s2_data_q;
    logic [DATA_W-1:0]   fwd_data;
    logic [DATA_W-1:0]   rdata_q;
    logic                rvalid_q;
    logic                fwd_hit;
    zbt_op_e             s1_op_w, s2_op_w;

    assign s1_op_w   = s1_q.op;
    assign s2_op_w   = s2_q.op;
    assign mem_raddr = s1_q.addr;
    assign mem_we    = clk_en && (s2_q.op == OP_WRITE);
    assign mem_waddr = s2_q.addr;
    assign mem_wbe   = s2_q.be;
    assign fwd_hit   = (s2_q.op == OP_WRITE) && (s2_q.addr == s1_q.addr);

    // A write committing on the same edge as the array read is merged in
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd_data[l*LANE_W +: LANE_W] = (fwd_hit && s2_q.be[l]) ?
            wdata[l*LANE_W +: LANE_W] : mem_rdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '{op: OP_IDLE, addr: '0, be: '0};
            s2_q      <= '{op: OP_IDLE, addr: '0, be: '0};
            s2_data_q <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
        end else if (clk_en) begin
            s1_q      <= '{op: cmd_op, addr: cmd_addr, be: cmd_be};
            s2_q      <= s1_q;
            s2_data_q <= fwd_data;
            rvalid_q  <= (s2_q.op == OP_READ);
            if (s2_q.op == OP_READ) rdata_q <= s2_data_q;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    assert_rvalid_from_read_R2: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> (rvalid == ($past(s2_op_w) == OP_READ)));

    assert_stage_shift_R4: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> (s2_op_w == $past(s1_op_w)));

    assert_freeze_out_R7: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(rvalid) && $stable(rdata) && $stable(s1_op_w)));

    assert_write_slot_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s2_op_w == OP_WRITE) |=> !rvalid);

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CS_W   = 3,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [CS_W-1:0]   chip_sel,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    zbt_op_e             cmd_op;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [LANES-1:0]    cmd_be;
    logic [ADDR_W-1:0]   mem_raddr, mem_waddr;
    logic [DATA_W-1:0]   mem_rdata;
    logic                mem_we;
    logic [LANES-1:0]    mem_wbe;

    zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .CS_W(CS_W), .LANES(LANES)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .chip_sel  (chip_sel),
        .adv_ld    (adv_ld),
        .rd_wr     (rd_wr),
        .burst_lin (burst_lin),
        .addr      (addr),
        .byte_en   (byte_en),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be)
    );

    zbt_data_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be),
        .wdata     (wdata),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wbe   (mem_wbe),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wbe   (mem_wbe),
        .wdata (wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;

    localparam int AW = 10;
    localparam int DW = 36;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b0;
    logic [2:0]    chip_sel = 3'b000;
    logic          adv_ld = 1'b0;
    logic          rd_wr = 1'b1;
    logic          burst_lin = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    byte_en = 4'h0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    // Reference model state (op: 0 idle, 1 read, 2 write)
    logic [DW-1:0] mm [1024];
    int            m_bop = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    int            q1_op = 0, q2_op = 0;
    logic [AW-1:0] q1_a = '0, q2_a = '0;
    logic [3:0]    q1_be = '0, q2_be = '0;
    logic          exp_v = 1'b0;
    logic [DW-1:0] exp_d = '0;
    logic          prev_v = 1'b0;
    logic [DW-1:0] prev_d = '0;

    zbt_sram u_zbt_sram (
        .clk(clk), .rst(rst), .clk_en(clk_en), .chip_sel(chip_sel),
        .adv_ld(adv_ld), .rd_wr(rd_wr), .burst_lin(burst_lin), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] old,
                                                  input logic [DW-1:0] nw,
                                                  input logic [3:0] be);
        logic [DW-1:0] r = old;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [1:0] exp_off(input logic [1:0] b, input logic [1:0] n,
                                           input logic lin);
        return lin ? 2'(b + n) : (b ^ n);
    endfunction

    task automatic check(input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int            c_op;
        logic [AW-1:0] c_a;
        if (!clk_en) return;
        if (!adv_ld) begin
            c_op   = (&chip_sel) ? (rd_wr ? 1 : 2) : 0;
            c_a    = addr;
            m_base = addr;
            m_step = 2'd0;
            m_bop  = c_op;
        end else begin
            m_step = m_step + 2'd1;
            c_op   = m_bop;
            c_a    = {m_base[AW-1:2], exp_off(m_base[1:0], m_step, burst_lin)};
        end
        if (q2_op == 1) begin
            exp_v = 1'b1;
            exp_d = mm[q2_a];
        end else begin
            exp_v = 1'b0;
        end
        if (q2_op == 2) mm[q2_a] = merge_lanes(mm[q2_a], wdata, q2_be);
        q2_op = q1_op; q2_a = q1_a; q2_be = q1_be;
        q1_op = c_op;  q1_a = c_a;  q1_be = byte_en;
    endtask

    task automatic tick(input logic en, input logic [2:0] cs, input logic adv,
                        input logic rw, input logic [AW-1:0] a, input logic [3:0] be);
        @(negedge clk);
        clk_en = en; chip_sel = cs; adv_ld = adv; rd_wr = rw; addr = a; byte_en = be;
        wdata = {$urandom, $urandom};
        @(posedge clk);
        model_edge();
        #1;
        if (en) begin
            check(rvalid == exp_v, DW'(rvalid), DW'(exp_v), "rvalid");
            if (exp_v) check(rdata == exp_d, rdata, exp_d, "rdata");
        end else begin
            check(rvalid == prev_v && rdata == prev_d, rdata, prev_d, "frozen output");
        end
        prev_v = rvalid;
        prev_d = rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] be);
        tick(1'b1, 3'b111, 1'b0, 1'b0, a, be);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        tick(1'b1, 3'b111, 1'b0, 1'b1, a, 4'h0);
    endtask
    task automatic adv(input logic [3:0] be);
        tick(1'b1, 3'b111, 1'b1, 1'b0, '0, be);
    endtask
    task automatic idle();
        tick(1'b1, 3'b000, 1'b0, 1'b1, '0, 4'h0);
    endtask
    task automatic stall();
        tick(1'b0, 3'b111, 1'b0, 1'b0, 10'd5, 4'hF);
    endtask
    task automatic drain();
        idle(); idle(); idle();
    endtask

    initial begin
        #(WATCHDOG * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mm[i] = '0;

        // R1: reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        #1;
        check(rvalid == 1'b0, DW'(rvalid), '0, "rvalid in reset");
        check(rdata == '0, rdata, '0, "rdata in reset");
        @(negedge clk);
        rst = 1'b0;

        // Fill the working range with full-word writes (R3)
        tag = "R3";
        for (int i = 0; i < 32; i++) wr(AW'(i), 4'hF);
        drain();
        for (int i = 0; i < 32; i++) rd(AW'(i));
        drain();

        // R8: read right after write to the same address, and one apart
        tag = "R8";
        wr(10'd7, 4'hF); rd(10'd7);
        wr(10'd8, 4'b0110); rd(10'd8);
        wr(10'd9, 4'hF); idle(); rd(10'd9);
        drain();

        // R4 and R10: strict alternation on one address and its neighbour
        tag = "R4";
        wr(10'd10, 4'hF); rd(10'd10); wr(10'd11, 4'hF); rd(10'd11);
        rd(10'd10); wr(10'd10, 4'b1001); rd(10'd10); rd(10'd11);
        drain();
        tag = "R10";
        wr(10'd12, 4'hF); wr(10'd13, 4'hF); idle(); rd(10'd12); wr(10'd12, 4'hF);
        drain();

        // R5: lane masks, including an empty mask
        tag = "R5";
        wr(10'd14, 4'b0101); wr(10'd14, 4'b0000); rd(10'd14);
        wr(10'd15, 4'b1000); rd(10'd15); wr(10'd15, 4'b0001); rd(10'd15);
        drain();

        // R6: each single select low on writes and reads, advance after deselect
        tag = "R6";
        tick(1'b1, 3'b011, 1'b0, 1'b0, 10'd3, 4'hF);
        tick(1'b1, 3'b101, 1'b0, 1'b0, 10'd3, 4'hF);
        tick(1'b1, 3'b110, 1'b0, 1'b1, 10'd3, 4'h0);
        tick(1'b1, 3'b110, 1'b1, 1'b0, 10'd3, 4'hF);
        rd(10'd3);
        drain();

        // R7: stalls inside a write's data window and between read stages
        tag = "R7";
        wr(10'd4, 4'hF); stall(); rd(10'd4); stall(); stall(); idle(); stall(); idle();
        rd(10'd4); stall(); stall(); idle(); stall(); idle();
        drain();

        // R9: linear and interleaved bursts from unaligned bases
        tag = "R9";
        burst_lin = 1'b1;
        wr(10'd21, 4'hF); adv(4'hF); adv(4'b0011); adv(4'hF); adv(4'hF);
        rd(10'd21); adv(4'h0); adv(4'h0); adv(4'h0); adv(4'h0);
        drain();
        burst_lin = 1'b0;
        rd(10'd22); adv(4'h0); adv(4'h0); adv(4'h0);
        wr(10'd27, 4'hF); adv(4'hF); adv(4'hF); adv(4'hF);
        rd(10'd24); adv(4'h0); adv(4'h0); adv(4'h0);
        drain();
        tick(1'b1, 3'b101, 1'b0, 1'b1, 10'd24, 4'h0); adv(4'hF); adv(4'hF);
        drain();

        // Random mix against the model (R2, R4, R8)
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            logic en   = ($urandom % 10) != 0;
            logic [2:0] cs = (($urandom % 8) == 0) ? 3'($urandom) : 3'b111;
            logic av   = ($urandom % 4) == 0;
            burst_lin  = 1'($urandom);
            tick(en, cs, av, 1'($urandom), AW'($urandom % 32), 4'($urandom));
        end
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule